// File: doc/BRIEF.md
# Hardware Loop Sequencer

This block sits beside a program counter and repeats code without branch instructions. A loop command supplies a first address, a last address, an iteration count and a mode. In block mode the range from the first address to the last address is repeated. In single mode only the instruction at the first address is repeated.

Every time an instruction retires at the last address and further passes remain, the block presents the first address as the next PC in that same cycle. The fetch logic takes it in place of the sequential address, so the loop costs no extra cycles. On the final pass nothing is presented, the program runs on past the loop, and the active flag drops.

The count field is 8 bits wide. A value of 0 selects the largest count, 256 passes. While a single-mode loop runs, the block asks the interrupt controller to hold interrupts off. Only one loop level exists. A command that arrives while a loop runs is dropped, and a one-cycle reject pulse reports it.

Top module: `hwloop_seq`

## Requirements
- R1: After synchronous reset, `loop_active`, `irq_hold`, `cmd_reject` and `redirect_valid` are all 0.
- R2: While a loop is active, an advance (`adv`=1) at the loop's last address with passes remaining drives `redirect_valid`=1 and `redirect_pc`=first address in that same cycle, with no idle cycle inserted.
- R3: A count N in 1..255 gives exactly N passes: N-1 redirects, then the advance at the last address on the final pass gives no redirect, and `loop_active` is 0 from the next cycle on.
- R4: A count field of 0 gives 256 passes (255 redirects).
- R5: With `cmd_single`=1 the loop body is the first address alone and `cmd_last` is ignored. `irq_hold` is 1 exactly while such a loop is active. It stays 0 for block loops (`cmd_single`=0).
- R6: A `cmd_valid` while `loop_active`=1 leaves the running loop unchanged: it keeps its addresses, pass count and mode. `cmd_reject` is 1 for the one cycle after it.
- R7: With `adv`=0, `redirect_valid` is 0 and the remaining pass count does not change, even when `pc` equals the last address.
- R8: A `cmd_valid` while idle makes `loop_active` 1 from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Loop start command |
| cmd_single | input | 1 | 1: single-instruction repeat, 0: block loop |
| cmd_first | input | ADDR_W | Loop first address |
| cmd_last | input | ADDR_W | Loop last address (block mode only) |
| cmd_count | input | CNT_W | Pass count, 0 means 2^CNT_W |
| pc | input | ADDR_W | Address of the instruction now retiring |
| adv | input | 1 | Instruction advance strobe |
| redirect_valid | output | 1 | Replace the next PC with redirect_pc |
| redirect_pc | output | ADDR_W | Loop-back address |
| loop_active | output | 1 | A loop is running |
| irq_hold | output | 1 | Interrupt mask request |
| cmd_reject | output | 1 | Pulse: a command arrived while busy |

## Verification
A rejected command and a loop-back redirect can fall in the same cycle, because the running loop must keep wrapping while a second command is dropped. The bench provokes this by raising `cmd_valid` on random cycles inside loops that still have passes left, including cycles where `pc` sits at the last address with `adv` high. It judges the outcome in two ways: `cmd_reject` must pulse on the next cycle, and the redirects that follow must still match the original loop's addresses and remaining count. A final-pass advance combined with a rejected command would be dropped in the same way.

// File: rtl/hwl_pkg.sv
package hwl_pkg;
  typedef enum logic {
    MODE_BLOCK  = 1'b0,
    MODE_SINGLE = 1'b1
  } loop_mode_e;
endpackage

// File: rtl/hwl_cfg_regs.sv
module hwl_cfg_regs
  import hwl_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  loop_mode_e        cmd_mode,
  input  logic [ADDR_W-1:0] cmd_first,
  input  logic [ADDR_W-1:0] cmd_last,
  input  logic              finish,
  output logic              accept,
  output logic              active,
  output logic              hold,
  output logic              reject,
  output logic [ADDR_W-1:0] first_q,
  output logic [ADDR_W-1:0] last_q
);
  loop_mode_e mode_q;

  assign accept = cmd_valid && !active;

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      hold    <= 1'b0;
      reject  <= 1'b0;
      mode_q  <= MODE_BLOCK;
      first_q <= '0;
      last_q  <= '0;
    end else begin
      reject <= cmd_valid && active;
      if (accept) begin
        active  <= 1'b1;
        mode_q  <= cmd_mode;
        hold    <= (cmd_mode == MODE_SINGLE);
        first_q <= cmd_first;
        last_q  <= (cmd_mode == MODE_SINGLE) ? cmd_first : cmd_last;
      end else if (finish) begin
        active <= 1'b0;
        hold   <= 1'b0;
      end
    end
  end

  AST_START_ON_CMD: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !active) |=> active);                          // R8
  AST_REJECT_WHEN_BUSY: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && active) |=> (reject && $stable(first_q) && $stable(last_q))); // R6
  AST_HOLD_ONLY_SINGLE: assert property (@(posedge clk) disable iff (rst)
    hold |-> (active && mode_q == MODE_SINGLE));                 // R5
endmodule

// File: rtl/hwl_iter_cnt.sv
module hwl_iter_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] count_in,
  input  logic             step,
  output logic             final_pass
);
  logic [CNT_W-1:0] left_q;

  // left_q holds passes remaining minus one; a count of 0 wraps to all ones.
  always_ff @(posedge clk) begin
    if (rst) begin
      left_q <= '0;
    end else if (load) begin
      left_q <= count_in - CNT_W'(1);
    end else if (step) begin
      left_q <= left_q - CNT_W'(1);
    end
  end

  assign final_pass = (left_q == '0);

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    (step && !load) |-> !final_pass);                            // R3
endmodule

// File: rtl/hwl_wrap_detect.sv
module hwl_wrap_detect #(
  parameter int ADDR_W = 16
) (
  input  logic              active,
  input  logic              adv,
  input  logic [ADDR_W-1:0] pc,
  input  logic [ADDR_W-1:0] last_addr,
  input  logic              final_pass,
  output logic              wrap,
  output logic              finish
);
  logic at_end;

  assign at_end = active && adv && (pc == last_addr);
  assign wrap   = at_end && !final_pass;
  assign finish = at_end && final_pass;
endmodule

// File: rtl/hwloop_seq.sv
module hwloop_seq
  import hwl_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic              cmd_single,
  input  logic [ADDR_W-1:0] cmd_first,
  input  logic [ADDR_W-1:0] cmd_last,
  input  logic [CNT_W-1:0]  cmd_count,
  input  logic [ADDR_W-1:0] pc,
  input  logic              adv,
  output logic              redirect_valid,
  output logic [ADDR_W-1:0] redirect_pc,
  output logic              loop_active,
  output logic              irq_hold,
  output logic              cmd_reject
);
  logic              accept;
  logic              finish;
  logic              wrap;
  logic              final_pass;
  logic [ADDR_W-1:0] first_q;
  logic [ADDR_W-1:0] last_q;
  loop_mode_e        mode_in;

  assign mode_in = cmd_single ? MODE_SINGLE : MODE_BLOCK;

  hwl_cfg_regs #(.ADDR_W(ADDR_W)) u_cfg (
    .clk      (clk),
    .rst      (rst),
    .cmd_valid(cmd_valid),
    .cmd_mode (mode_in),
    .cmd_first(cmd_first),
    .cmd_last (cmd_last),
    .finish   (finish),
    .accept   (accept),
    .active   (loop_active),
    .hold     (irq_hold),
    .reject   (cmd_reject),
    .first_q  (first_q),
    .last_q   (last_q)
  );

  hwl_iter_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .load      (accept),
    .count_in  (cmd_count),
    .step      (wrap),
    .final_pass(final_pass)
  );

  hwl_wrap_detect #(.ADDR_W(ADDR_W)) u_det (
    .active    (loop_active),
    .adv       (adv),
    .pc        (pc),
    .last_addr (last_q),
    .final_pass(final_pass),
    .wrap      (wrap),
    .finish    (finish)
  );

  assign redirect_valid = wrap;
  assign redirect_pc    = first_q;

  AST_REDIRECT_IN_LOOP: assert property (@(posedge clk) disable iff (rst)
    redirect_valid |-> loop_active);                             // R2
  AST_IDLE_NO_REDIRECT: assert property (@(posedge clk) disable iff (rst)
    !adv |-> !redirect_valid);                                   // R7
  AST_FINISH_DROPS: assert property (@(posedge clk) disable iff (rst)
    (finish && !cmd_valid) |=> !loop_active);                    // R3
endmodule

// File: tb/hwloop_seq_bench.sv
module hwloop_seq_bench;
  localparam int AW = 16;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_valid = 1'b0, cmd_single = 1'b0;
  logic [AW-1:0] cmd_first = '0, cmd_last = '0, pc = '0;
  logic [CW-1:0] cmd_count = '0;
  logic          adv = 1'b0;
  logic          redirect_valid, loop_active, irq_hold, cmd_reject;
  logic [AW-1:0] redirect_pc;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  hwloop_seq #(.ADDR_W(AW), .CNT_W(CW)) u_hwloop_seq (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_single(cmd_single),
    .cmd_first(cmd_first), .cmd_last(cmd_last), .cmd_count(cmd_count),
    .pc(pc), .adv(adv), .redirect_valid(redirect_valid),
    .redirect_pc(redirect_pc), .loop_active(loop_active),
    .irq_hold(irq_hold), .cmd_reject(cmd_reject)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int passes_of(input logic [CW-1:0] c);
    return (c == '0) ? (1 << CW) : int'(c);
  endfunction

  // Runs one loop; inject_rej enables busy commands during the loop.
  task automatic run_loop(input logic [AW-1:0] first, input int len,
                          input logic [CW-1:0] cnt, input bit single,
                          input bit inject_rej, input int adv_pct);
    int            remaining;
    int            redirects;
    logic [AW-1:0] last_e;
    logic [AW-1:0] cur;
    bit            exp_redir;
    bit            rej_pend;
    remaining = passes_of(cnt);
    last_e    = single ? first : first + AW'(len);
    redirects = 0;
    rej_pend  = 0;
    @(negedge clk);
    cmd_valid  = 1'b1;
    cmd_single = single;
    cmd_first  = first;
    cmd_last   = single ? first + AW'(3) : last_e;  // junk last in single mode
    cmd_count  = cnt;
    adv        = 1'b0;
    pc         = first;
    cur        = first;
    @(negedge clk);
    cmd_valid = 1'b0;
    check("R8 active after start", loop_active, 1);
    check("R5 irq_hold by mode", irq_hold, single);
    while (remaining > 0) begin
      if (rej_pend) begin
        check("R6 reject pulse", cmd_reject, 1);
        rej_pend  = 0;
        cmd_valid = 1'b0;
      end
      check("R3 active during loop", loop_active, 1);
      if (single) check("R5 hold while single", irq_hold, 1);
      adv = ($urandom_range(99) < adv_pct);
      pc  = cur;
      if (inject_rej && remaining > 1 && $urandom_range(9) == 0) begin
        cmd_valid  = 1'b1;
        cmd_single = ~single;
        cmd_first  = first + AW'(100);
        cmd_last   = first + AW'(101);
        cmd_count  = 8'd2;
        rej_pend   = 1;
      end
      #1;
      exp_redir = adv && (cur == last_e) && (remaining > 1);
      check(adv ? "R2 redirect" : "R7 no redirect without adv", redirect_valid, exp_redir);
      if (exp_redir) check("R2 redirect pc", redirect_pc, first);
      if (adv) begin
        if (cur == last_e) begin
          if (remaining > 1) redirects++;
          remaining--;
          cur = first;
        end else begin
          cur = cur + AW'(1);
        end
      end
      @(negedge clk);
    end
    if (rej_pend) begin
      check("R6 reject pulse", cmd_reject, 1);
      cmd_valid = 1'b0;
    end
    adv = 1'b0;
    check(cnt == 0 ? "R4 redirect total" : "R3 redirect total", redirects, passes_of(cnt) - 1);
    check("R3 inactive after last pass", loop_active, 0);
    check("R5 hold cleared", irq_hold, 0);
    @(negedge clk);
    check("R6 no stray reject", cmd_reject, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check("R1 loop_active reset", loop_active, 0);
    check("R1 irq_hold reset", irq_hold, 0);
    check("R1 cmd_reject reset", cmd_reject, 0);
    check("R1 redirect reset", redirect_valid, 0);
    rst = 1'b0;
    @(negedge clk);
    // R7: at last address with adv low while idle: nothing
    pc = 16'h0010; adv = 1'b0; #1;
    check("R7 idle no redirect", redirect_valid, 0);
    // Directed corners
    run_loop(16'h0100, 2, 8'd1, 0, 0, 100);   // R3 single pass, no redirect
    run_loop(16'h0200, 0, 8'd3, 0, 0, 100);   // block of one instruction
    run_loop(16'h0300, 0, 8'd0, 1, 0, 100);   // R4 256 single repeats
    run_loop(16'h0400, 1, 8'd0, 0, 1, 70);    // R4 block, 256 passes, rejects
    run_loop(16'h0500, 3, 8'd255, 0, 0, 100); // R3 max explicit count
    run_loop(16'h0600, 2, 8'd5, 0, 1, 30);    // R7 sparse advance
    // Random loops
    for (int i = 0; i < 30; i++) begin
      run_loop(AW'($urandom_range(16'hF000)), $urandom_range(4),
               CW'($urandom_range(1, 12)), bit'($urandom_range(1)),
               1, $urandom_range(40, 100));
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule